// File: doc/BRIEF.md
# Instruction Class Decoder

This block sorts a 32-bit fixed-width instruction word into one of eighteen instruction classes. It also decides whether the instruction's condition allows it to run, given the current negative, zero, carry and overflow flags. The class is chosen from a 12-bit index only. That index joins the eight opcode bits 27:20 (upper part) with the four bits 7:4 (lower part). All other bits of the word are operands or the condition field and play no part in the class.

The class logic is combinational. The class code and the condition verdict are captured together in a single output register, so both results appear one clock after the word is presented. A dispatch stage downstream uses the class to choose an execution unit. It uses the condition verdict to suppress instructions whose condition fails.

Top module: `insn_class_decoder`

## Requirements
- R1: The class depends only on insn bits 27:20 and 7:4. Changing any of bits 31:28, 19:8 or 3:0 leaves cls_o unchanged.
- R2: cls_o and pass_o are registered, one cycle after insn and flags. A clock edge with rst_n low gives cls_o = 0 and pass_o = 0. Class codes: 0 undefined, 1 branch, 2 branch-exchange, 3 data-processing immediate, 4 data-processing immediate shift, 5 data-processing register shift, 6 halfword/signed transfer immediate offset, 7 halfword/signed transfer register offset, 8 swap, 9 single transfer immediate offset, 10 single transfer register offset, 11 block transfer, 12 status read, 13 status write immediate, 14 status write register, 15 multiply, 16 multiply-long, 17 software interrupt.
- R3: pass_o evaluates insn[31:28] against flags. The flags are ordered {N,Z,C,V} in flags[3:0]. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R4: Condition code 14 always passes and code 15 never passes, whatever the flags.
- R5: Bits 27:25 = 101 give class 1. The link bit 24 does not change the class.
- R6: Bits 27:20 = 00010010 with bits 7:4 = 0001 give class 2.
- R7: Bits 27:25 = 001 give class 3. Bits 27:25 = 000 give class 4 when bit 4 = 0, and class 5 when bit 7 = 0 and bit 4 = 1. In all three cases the opcode in bits 24:21 must not be in the range 8 to 11 while bit 20 is clear; such a word is never class 3, 4 or 5.
- R8: With bits 7:4 = 0000, bits 27:20 of 0001 0x00 give class 12 and 0001 0x10 give class 14. Bits 27:20 = 0011 0x10 give class 13.
- R9: With bits 7:4 = 1001, bits 27:20 of 0000 00xx give class 15 and 0000 1xxx give class 16.
- R10: Bits 27:20 = 0001 0x00 with bits 7:4 = 1001 give class 8.
- R11: With bits 27:25 = 000, a halfword/signed transfer is bits 7:4 = 1011, or bits 7:4 = 11x1 with bit 20 set. It is class 6 when bit 22 = 1 and class 7 when bit 22 = 0.
- R12: Bits 27:25 = 010 give class 9. Bits 27:25 = 011 with bit 4 = 0 give class 10.
- R13: Bits 27:25 = 100 give class 11. Bits 27:24 = 1111 give class 17.
- R14: Every index not covered by R5 to R13 gives class 0. Examples are bits 27:25 = 011 with bit 4 set, bits 27:24 = 110x or 1110, and bits 7:4 = 11x1 with bit 20 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn | input | 32 | Instruction word |
| flags | input | 4 | Status flags {N,Z,C,V} |
| cls_o | output | 5 | Registered class code |
| pass_o | output | 1 | Registered condition verdict |

## Verification
The embedded assertions check the following on every cycle:
- at most one class pattern claims any index;
- the reset value;
- the always and never condition codes;
- the branch, block-transfer and software-interrupt groups, one cycle later;
- that compare-type opcodes without bit 20 never land in a data-processing class.

Several behaviours can only be shown by the bench's scenarios:
- the finer class splits: status moves, swap, the multiply forms and the halfword forms;
- the full 16-by-16 condition table;
- the fall-through to undefined;
- the fact that non-index bits have no effect.

// File: rtl/icd_pkg.sv
// Package: shared widths and the class code enumeration for the
// instruction class decoder. Assumes a 32-bit fixed-width word.
package icd_pkg;
    localparam int INSN_W  = 32;
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 4;
    localparam int HI_W    = 8;
    localparam int LO_W    = 4;
    localparam int IDX_W   = HI_W + LO_W;
    localparam int CLS_N   = 18;
    localparam int CLS_W   = $clog2(CLS_N);

    typedef enum logic [CLS_W-1:0] {
        CL_UNDEF     = 5'd0,
        CL_BRANCH    = 5'd1,
        CL_BX        = 5'd2,
        CL_DP_IMM    = 5'd3,
        CL_DP_ISH    = 5'd4,
        CL_DP_RSH    = 5'd5,
        CL_HALF_IMM  = 5'd6,
        CL_HALF_REG  = 5'd7,
        CL_SWAP      = 5'd8,
        CL_XFER_IMM  = 5'd9,
        CL_XFER_REG  = 5'd10,
        CL_BLOCK     = 5'd11,
        CL_PSR_RD    = 5'd12,
        CL_PSR_WRI   = 5'd13,
        CL_PSR_WRR   = 5'd14,
        CL_MUL       = 5'd15,
        CL_MULL      = 5'd16,
        CL_SWI       = 5'd17
    } icd_class_e;
endpackage

// File: rtl/icd_cond_eval.sv
// Condition evaluator: decides from the 4-bit condition code and the
// {N,Z,C,V} flags whether the instruction may execute. Purely
// combinational; code 14 always passes, code 15 never does.
module icd_cond_eval
    import icd_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);
    logic fn, fz, fc, fv;
    assign {fn, fz, fc, fv} = flags;

    // Select the flag predicate named by the condition code.
    always_comb begin
        unique case (code)
            4'd0:  pass = fz;
            4'd1:  pass = !fz;
            4'd2:  pass = fc;
            4'd3:  pass = !fc;
            4'd4:  pass = fn;
            4'd5:  pass = !fn;
            4'd6:  pass = fv;
            4'd7:  pass = !fv;
            4'd8:  pass = fc && !fz;
            4'd9:  pass = !fc || fz;
            4'd10: pass = (fn == fv);
            4'd11: pass = (fn != fv);
            4'd12: pass = !fz && (fn == fv);
            4'd13: pass = fz || (fn != fv);
            4'd14: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/icd_class_match.sv
// Pattern matcher: one hit line per class code, computed from the
// 12-bit index {opcode bits 27:20, bits 7:4}. The patterns are meant
// to be disjoint, so at most one line is high; bit 0 (undefined) is
// never driven here and is implied by the absence of any hit.
module icd_class_match
    import icd_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [CLS_N-1:0] hit
);
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic [2:0]      grp;
    logic            cmp_nos;
    logic [6:0]      psr_key;
    logic            half_xfer;

    assign hi      = idx[IDX_W-1:LO_W];
    assign lo      = idx[LO_W-1:0];
    assign grp     = hi[7:5];
    // Compare-type opcode (8..11) with the S bit clear.
    assign cmp_nos = (hi[4:3] == 2'b10) && !hi[0];
    // Opcode bits with bit 22 masked out, for status/swap keys.
    assign psr_key = {hi[7:3], hi[1:0]};
    assign half_xfer = (grp == 3'b000) &&
                       ((lo == 4'b1011) || ((lo[3:2] == 2'b11) && lo[0] && hi[0]));

    // Drive each class hit line from its own pattern.
    always_comb begin
        hit              = '0;
        hit[CL_BRANCH]   = (grp == 3'b101);
        hit[CL_BX]       = (hi == 8'h12) && (lo == 4'b0001);
        hit[CL_DP_IMM]   = (grp == 3'b001) && !cmp_nos;
        hit[CL_DP_ISH]   = (grp == 3'b000) && !lo[0] && !cmp_nos;
        hit[CL_DP_RSH]   = (grp == 3'b000) && !lo[3] && lo[0] && !cmp_nos;
        hit[CL_HALF_IMM] = half_xfer && hi[2];
        hit[CL_HALF_REG] = half_xfer && !hi[2];
        hit[CL_SWAP]     = (psr_key == 7'b0001000) && (lo == 4'b1001);
        hit[CL_XFER_IMM] = (grp == 3'b010);
        hit[CL_XFER_REG] = (grp == 3'b011) && !lo[0];
        hit[CL_BLOCK]    = (grp == 3'b100);
        hit[CL_PSR_RD]   = (psr_key == 7'b0001000) && (lo == 4'b0000);
        hit[CL_PSR_WRI]  = (psr_key == 7'b0011010);
        hit[CL_PSR_WRR]  = (psr_key == 7'b0001010) && (lo == 4'b0000);
        hit[CL_MUL]      = (hi[7:2] == 6'b000000) && (lo == 4'b1001);
        hit[CL_MULL]     = (hi[7:3] == 5'b00001) && (lo == 4'b1001);
        hit[CL_SWI]      = (hi[7:4] == 4'b1111);
    end
endmodule

// File: rtl/icd_class_encode.sv
// Encoder: turns the one-hot-or-zero hit vector into a class code.
// Assumes at most one hit; no hit yields the undefined code 0.
module icd_class_encode
    import icd_pkg::*;
(
    input  logic [CLS_N-1:0] hit,
    output icd_class_e       cls
);
    logic [CLS_W-1:0] code;

    // OR together the index of every asserted hit line.
    always_comb begin
        code = '0;
        for (int k = 0; k < CLS_N; k++) begin
            if (hit[k]) code = code | CLS_W'(k);
        end
    end

    assign cls = icd_class_e'(code);
endmodule

// File: rtl/insn_class_decoder.sv
// Top: forms the 12-bit class index from bits 27:20 and 7:4, matches it
// against the class patterns, evaluates the condition field, and
// registers class and verdict together (latency one cycle). Reset is
// synchronous and active low.
module insn_class_decoder
    import icd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn,
    input  logic [FLAG_W-1:0] flags,
    output logic [CLS_W-1:0]  cls_o,
    output logic              pass_o
);
    logic [IDX_W-1:0] idx;
    logic [CLS_N-1:0] hit;
    icd_class_e       cls_d;
    logic             pass_d;
    icd_class_e       cls_q;
    logic             pass_q;
    logic             unused_operand_bits;

    assign idx = {insn[27:20], insn[7:4]};
    assign unused_operand_bits = ^{insn[19:8], insn[3:0]};

    icd_class_match u_match (
        .idx (idx),
        .hit (hit)
    );

    icd_class_encode u_encode (
        .hit (hit),
        .cls (cls_d)
    );

    icd_cond_eval u_cond (
        .code  (insn[31:28]),
        .flags (flags),
        .pass  (pass_d)
    );

    // Output stage: capture class and verdict, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= CL_UNDEF;
            pass_q <= 1'b0;
        end else begin
            cls_q  <= cls_d;
            pass_q <= pass_d;
        end
    end

    assign cls_o  = cls_q;
    assign pass_o = pass_q;

    AST_PATTERNS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R14
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cls_o == CL_UNDEF && !pass_o)); // R2
    AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[31:28] == 4'hE) |=> pass_o); // R4
    AST_COND_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[31:28] == 4'hF) |=> !pass_o); // R4
    AST_BRANCH_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[27:25] == 3'b101) |=> (cls_o == CL_BRANCH)); // R5
    AST_BLOCK_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[27:25] == 3'b100) |=> (cls_o == CL_BLOCK)); // R13
    AST_SWI_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[27:24] == 4'hF) |=> (cls_o == CL_SWI)); // R13
    AST_CMP_NOS_NOT_DP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[27:26] == 2'b00 && insn[24:23] == 2'b10 && !insn[20])
        |=> (cls_o != CL_DP_IMM && cls_o != CL_DP_ISH && cls_o != CL_DP_RSH)); // R7
endmodule

// File: tb/insn_class_decoder_test.sv
module insn_class_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [3:0]  flags = '0;
    logic [4:0]  cls_o;
    logic        pass_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    insn_class_decoder uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .insn   (insn),
        .flags  (flags),
        .cls_o  (cls_o),
        .pass_o (pass_o)
    );

    always #10 clk = ~clk;

    // Reference class from the requirement text.
    function automatic int ref_class(input logic [31:0] w);
        logic [7:0] h;
        logic [3:0] l;
        bit nos;
        h = w[27:20];
        l = w[7:4];
        nos = (w[24:23] == 2'b10) && !w[20];
        if (w[27:24] == 4'hF) return 17;
        if (w[27:25] == 3'b101) return 1;
        if (w[27:25] == 3'b100) return 11;
        if (w[27:25] == 3'b010) return 9;
        if (w[27:25] == 3'b011) return w[4] ? 0 : 10;
        if (w[27:25] == 3'b001) begin
            if (!nos) return 3;
            return w[21] ? 13 : 0;
        end
        if (w[27:25] == 3'b000) begin
            if (!w[4] || !w[7]) begin
                if (!nos) return w[4] ? 5 : 4;
                if (l == 4'h0) return w[21] ? 14 : 12;
                if (l == 4'h1 && h == 8'h12) return 2;
                return 0;
            end
            if (l == 4'h9) begin
                if (w[24:22] == 3'b000) return 15;
                if (w[24:23] == 2'b01) return 16;
                if (w[24:23] == 2'b10 && w[21:20] == 2'b00) return 8;
                return 0;
            end
            if (l == 4'hB) return w[22] ? 6 : 7;
            if (w[20]) return w[22] ? 6 : 7;
            return 0;
        end
        return 0;
    endfunction

    // Reference condition verdict, flags ordered {N,Z,C,V}.
    function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            0: return z;
            1: return !z;
            2: return cy;
            3: return !cy;
            4: return n;
            5: return !n;
            6: return v;
            7: return !v;
            8: return cy && !z;
            9: return !cy || z;
            10: return n == v;
            11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one word, sample the registered result one cycle later.
    task automatic apply(input logic [31:0] w, input logic [3:0] f,
                         output int c, output int p);
        @(negedge clk);
        insn = w;
        flags = f;
        @(negedge clk);
        c = int'(cls_o);
        p = int'(pass_o);
    endtask

    task automatic dir(input string req, input logic [31:0] w, input int exp_cls);
        int c, p;
        apply(w, 4'b0000, c, p);
        check(req, c, exp_cls);
        check(req, p, int'(ref_pass(w[31:28], 4'b0000)));
    endtask

    initial begin
        int c, p, c2, p2;
        logic [31:0] w;
        logic [3:0] f;
        void'($urandom(32'hC0DE5EED));
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 reset cls", int'(cls_o), 0);
        check("R2 reset pass", int'(pass_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        dir("R5 branch", 32'hEA000000, 1);
        dir("R5 branch link", 32'hEB123456, 1);
        dir("R6 bx", 32'hE12FFF11, 2);
        dir("R7 dp imm", 32'hE3A00001, 3);
        dir("R7 cmp with S", 32'hE1500001, 4);
        dir("R7 tst with S", 32'hE1100000, 4);
        dir("R7 reg shift", 32'hE1A00110, 5);
        dir("R7 nos reg-shift form undefined", 32'hE1200030, 0);
        dir("R8 status read", 32'hE10F0000, 12);
        dir("R8 status write imm", 32'hE328F000, 13);
        dir("R8 status write reg", 32'hE129F000, 14);
        dir("R9 mul", 32'hE0000091, 15);
        dir("R9 mull", 32'hE0800091, 16);
        dir("R10 swap", 32'hE1000091, 8);
        dir("R10 swap byte", 32'hE1400091, 8);
        dir("R11 half imm", 32'hE1C000B0, 6);
        dir("R11 half reg", 32'hE18000B0, 7);
        dir("R11 signed load imm", 32'hE1D000D0, 6);
        dir("R11 signed load reg", 32'hE19000F0, 7);
        dir("R14 signed store undefined", 32'hE1C000D0, 0);
        dir("R12 xfer imm", 32'hE5900000, 9);
        dir("R12 xfer reg", 32'hE7900000, 10);
        dir("R14 xfer reg bit4", 32'hE7900010, 0);
        dir("R13 block", 32'hE8900000, 11);
        dir("R13 swi", 32'hEF000000, 17);
        dir("R14 coproc space", 32'hEC000000, 0);
        dir("R14 coproc space 2", 32'hEE000000, 0);

        // R3/R4: full condition table with a branch word
        for (int cc = 0; cc < 16; cc++) begin
            for (int ff = 0; ff < 16; ff++) begin
                apply({cc[3:0], 28'hA000000}, ff[3:0], c, p);
                if (cc >= 14) check("R4 always/never", p, int'(ref_pass(cc[3:0], ff[3:0])));
                else check("R3 condition", p, int'(ref_pass(cc[3:0], ff[3:0])));
                check("R5 class under any cond", c, 1);
            end
        end

        // Constrained random words
        for (int i = 0; i < 3000; i++) begin
            int k;
            w = $urandom;
            f = 4'($urandom);
            k = int'($urandom % 4);
            if (k == 0) begin
                w[27:25] = 3'b000;
                w[7] = 1'b1;
                w[4] = 1'b1;
            end else if (k == 1) begin
                w[27:23] = 5'b00010;
                w[7:4] = ($urandom % 2) ? 4'b0000 : (($urandom % 2) ? 4'b0001 : 4'b1001);
            end
            apply(w, f, c, p);
            check("R7-R14 random class", c, ref_class(w));
            check("R3 random pass", p, int'(ref_pass(w[31:28], f)));
        end

        // R1: operand and condition bits do not move the class
        for (int i = 0; i < 300; i++) begin
            w = $urandom;
            if (i % 2 == 0) w[27:25] = 3'b000;
            apply(w, 4'($urandom), c, p);
            w[31:28] = 4'($urandom);
            w[19:8] = 12'($urandom);
            w[3:0] = 4'($urandom);
            apply(w, 4'($urandom), c2, p2);
            check("R1 non-index bits ignored", c2, c);
        end

        // R2: reset in mid-run clears the outputs
        @(negedge clk);
        insn = 32'hEA000000;
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid reset cls", int'(cls_o), 0);
        check("R2 mid reset pass", int'(pass_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset cls", int'(cls_o), 1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule